// File: doc/BRIEF.md
# Line-Synchronous PI Power Compensator

This block produces the power demand word for a power-factor correction stage. It does not run on every clock. It updates once for each line-valley strobe, a one-cycle pulse raised by upstream logic when the input mains crosses zero. At each strobe it samples the following:

- a target output-voltage code and a measured output-voltage code;
- two 3-bit gain selectors.

From the two voltage codes it forms a saturated signed error. It then adds a proportional term, twice the selected proportional gain times the error, to an integral term, the selected integral gain times a running sum of errors.

The sum is clamped to the range zero to a parameterised ceiling, and is presented as a registered word with a one-cycle valid pulse. The integrator saturates at its own limits and never wraps. It stops moving in the direction that would drive the output deeper into the clamp. A synchronous enable, when low, clears the integrator and holds the output at zero.

Top module: `pfc_pi_comp`

## Requirements
- R1: A strobe sampled high with `en` high at rising edge N updates `pwr_dem` at edge N+1. At that same edge `pwr_vld` goes high for exactly one cycle. Strobes in consecutive cycles give valid pulses in consecutive cycles.
- R2: The error is `v_target - v_meas`, taking both codes as unsigned. It is saturated to the 12-bit two's-complement range -2048 to +2047.
- R3: Integral gain code 0 to 7 on `ki_sel` selects Ki = 4, 6, 8, 12, 16, 24, 32, 48 respectively.
- R4: Proportional gain code 0 to 7 on `kp_sel` selects Kp = 8, 12, 16, 24, 32, 48, 64, 96 respectively. The proportional term is 2·Kp·err.
- R5: The candidate sum is S = A + err, where A is the stored integrator. The unclamped result is 2·Kp·err + Ki·S. Unless R6 or R7 holds the integrator, S becomes the new integrator value.
- R6: A result above OUT_MAX is output as OUT_MAX (default 50000). If the error is also positive, the integrator keeps its old value.
- R7: A negative result is output as 0. If the error is also negative, the integrator keeps its old value.
- R8: The candidate sum S saturates at the signed ACC_W-bit limits (default 24) and never wraps.
- R9: While `en` is low, the integrator is cleared, `pwr_dem` is 0 and `pwr_vld` is 0. This includes a strobe taken one cycle before `en` fell, which then produces no pulse.
- R10: The gains and voltage codes are taken in the strobe cycle. Changes made to them after that cycle do not affect the result of that strobe.
- R11: Between strobes, `pwr_dem` and the integrator hold their values, and `pwr_vld` stays low.
- R12: Synchronous active-high `rst` clears the integrator, `pwr_dem` and `pwr_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Loop enable; low clears and holds zero |
| valley | input | 1 | One-cycle line-valley strobe |
| v_target | input | VCODE_W | Target output-voltage code |
| v_meas | input | VCODE_W | Measured output-voltage code |
| ki_sel | input | 3 | Integral gain code |
| kp_sel | input | 3 | Proportional gain code |
| pwr_dem | output | OUT_W | Registered power demand word |
| pwr_vld | output | 1 | One-cycle pulse when `pwr_dem` is updated |

## Verification
The enable clearing the loop and a strobe being processed can occur in the same cycle. The bench provokes this two ways:

- a strobe raised while `en` is already low;
- a strobe that `en` drops one cycle after, while the captured error is still inside the pipeline.

In both cases the check requires that no valid pulse appears and that `pwr_dem` reads zero. A following zero-error strobe must then return zero, which shows the integrator was really cleared and not merely masked.

// File: rtl/pfc_pi_pkg.sv
package pfc_pi_pkg;

  localparam int GSEL_W = 3;
  localparam int KI_W   = 6;
  localparam int KP2_W  = 8;

  typedef struct packed {
    logic [KI_W-1:0]  ki;
    logic [KP2_W-1:0] kp2;
  } gain_t;

  // Integral gain: mantissa 2 or 3, shifted by one more than the upper code bits
  function automatic logic [KI_W-1:0] ki_decode(input logic [GSEL_W-1:0] c);
    logic [KI_W-1:0] m;
    m = c[0] ? KI_W'(3) : KI_W'(2);
    return m << (int'(c[2:1]) + 1);
  endfunction

  // Doubled proportional gain: same mantissa, two more shift steps (x2 of Kp)
  function automatic logic [KP2_W-1:0] kp2_decode(input logic [GSEL_W-1:0] c);
    logic [KP2_W-1:0] m;
    m = c[0] ? KP2_W'(3) : KP2_W'(2);
    return m << (int'(c[2:1]) + 3);
  endfunction

endpackage

// File: rtl/pfc_gain_lut.sv
module pfc_gain_lut
  import pfc_pi_pkg::*;
(
  input  logic [GSEL_W-1:0] ki_sel,
  input  logic [GSEL_W-1:0] kp_sel,
  output gain_t             gain
);

  localparam int N_CODES = 2 ** GSEL_W;

  logic [KI_W-1:0]  ki_tab [N_CODES];
  logic [KP2_W-1:0] kp_tab [N_CODES];

  for (genvar i = 0; i < N_CODES; i++) begin : g_tab
    assign ki_tab[i] = ki_decode(GSEL_W'(i));
    assign kp_tab[i] = kp2_decode(GSEL_W'(i));
  end

  assign gain.ki  = ki_tab[ki_sel];
  assign gain.kp2 = kp_tab[kp_sel];

endmodule

// File: rtl/pfc_err_stage.sv
module pfc_err_stage
  import pfc_pi_pkg::*;
#(
  parameter int VCODE_W = 12,
  parameter int ERR_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    valley,
  input  logic [VCODE_W-1:0]      v_target,
  input  logic [VCODE_W-1:0]      v_meas,
  input  gain_t                   gain_in,
  output logic                    s1_vld,
  output logic signed [ERR_W-1:0] s1_err,
  output gain_t                   s1_gain
);

  localparam int DW = VCODE_W + ERR_W + 2;
  localparam logic signed [DW-1:0] EMAX = DW'({1'b0, {(ERR_W-1){1'b1}}});
  localparam logic signed [DW-1:0] EMIN = ~EMAX;

  logic signed [DW-1:0]    diff;
  logic signed [ERR_W-1:0] err_sat;

  assign diff = $signed(DW'(v_target)) - $signed(DW'(v_meas));

  always_comb begin
    if (diff > EMAX)      err_sat = EMAX[ERR_W-1:0];
    else if (diff < EMIN) err_sat = EMIN[ERR_W-1:0];
    else                  err_sat = diff[ERR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      s1_vld  <= 1'b0;
      s1_err  <= '0;
      s1_gain <= '0;
    end else begin
      s1_vld <= valley;
      if (valley) begin
        s1_err  <= err_sat;
        s1_gain <= gain_in;
      end
    end
  end

  // R10: captured operands only change on a strobe
  a_r10_capture_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !valley) |=> ($stable(s1_err) && $stable(s1_gain)));

  // R1: an enabled strobe always reaches the second stage
  a_r1_stage_vld: assert property (@(posedge clk) disable iff (rst)
    (en && valley) |=> s1_vld);

endmodule

// File: rtl/pfc_pi_core.sv
module pfc_pi_core
  import pfc_pi_pkg::*;
#(
  parameter int ERR_W   = 12,
  parameter int ACC_W   = 24,
  parameter int OUT_W   = 16,
  parameter int OUT_MAX = 50000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    s1_vld,
  input  logic signed [ERR_W-1:0] s1_err,
  input  gain_t                   s1_gain,
  output logic [OUT_W-1:0]        pwr_dem,
  output logic                    pwr_vld
);

  localparam int SW = ACC_W + ERR_W + KI_W + KP2_W;
  localparam logic signed [ACC_W:0]  AMAX = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W:0]  AMIN = ~AMAX;
  localparam logic signed [SW-1:0]   OMAX = SW'(OUT_MAX);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W:0]   acc_wide;
  logic signed [ACC_W-1:0] acc_cand;
  logic signed [SW-1:0]    p_term;
  logic signed [SW-1:0]    i_term;
  logic signed [SW-1:0]    raw;
  logic                    over;
  logic                    under;
  logic                    err_pos;
  logic                    err_neg;
  logic                    freeze;
  logic [OUT_W-1:0]        out_nxt;

  // Integrator candidate with saturation
  assign acc_wide = (ACC_W+1)'(acc_q) + (ACC_W+1)'(s1_err);

  always_comb begin
    if (acc_wide > AMAX)      acc_cand = AMAX[ACC_W-1:0];
    else if (acc_wide < AMIN) acc_cand = AMIN[ACC_W-1:0];
    else                      acc_cand = acc_wide[ACC_W-1:0];
  end

  // Proportional and integral products
  assign p_term = SW'(s1_err)   * $signed(SW'(s1_gain.kp2));
  assign i_term = SW'(acc_cand) * $signed(SW'(s1_gain.ki));
  assign raw    = p_term + i_term;

  assign over    = raw > OMAX;
  assign under   = raw[SW-1];
  assign err_neg = s1_err[ERR_W-1];
  assign err_pos = !s1_err[ERR_W-1] && (s1_err != '0);
  assign freeze  = (over && err_pos) || (under && err_neg);

  always_comb begin
    if (over)       out_nxt = OUT_W'(OUT_MAX);
    else if (under) out_nxt = '0;
    else            out_nxt = raw[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      acc_q   <= '0;
      pwr_dem <= '0;
      pwr_vld <= 1'b0;
    end else begin
      pwr_vld <= s1_vld;
      if (s1_vld) begin
        pwr_dem <= out_nxt;
        if (!freeze) acc_q <= acc_cand;
      end
    end
  end

  // R6: output never exceeds the ceiling
  a_r6_out_cap: assert property (@(posedge clk) disable iff (rst)
    pwr_dem <= OUT_W'(OUT_MAX));

  // R8: a positive error never lowers the integrator (no wrap)
  a_r8_pos_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && s1_vld && err_pos) |=> (acc_q >= $past(acc_q)));

  // R8: a negative error never raises the integrator (no wrap)
  a_r8_neg_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && s1_vld && err_neg) |=> (acc_q <= $past(acc_q)));

  // R11: state holds between strobes
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !s1_vld) |=> ($stable(pwr_dem) && $stable(acc_q) && !pwr_vld));

  // R9: disabled loop is cleared
  a_r9_disable: assert property (@(posedge clk) disable iff (rst)
    !en |=> (pwr_dem == '0 && !pwr_vld && acc_q == '0));

endmodule

// File: rtl/pfc_pi_comp.sv
module pfc_pi_comp
  import pfc_pi_pkg::*;
#(
  parameter int VCODE_W = 12,
  parameter int ERR_W   = 12,
  parameter int ACC_W   = 24,
  parameter int OUT_W   = 16,
  parameter int OUT_MAX = 50000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               valley,
  input  logic [VCODE_W-1:0] v_target,
  input  logic [VCODE_W-1:0] v_meas,
  input  logic [2:0]         ki_sel,
  input  logic [2:0]         kp_sel,
  output logic [OUT_W-1:0]   pwr_dem,
  output logic               pwr_vld
);

  gain_t                   gain_dec;
  gain_t                   s1_gain;
  logic                    s1_vld;
  logic signed [ERR_W-1:0] s1_err;

  pfc_gain_lut u_lut (
    .ki_sel (ki_sel),
    .kp_sel (kp_sel),
    .gain   (gain_dec)
  );

  pfc_err_stage #(
    .VCODE_W (VCODE_W),
    .ERR_W   (ERR_W)
  ) u_err (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .valley   (valley),
    .v_target (v_target),
    .v_meas   (v_meas),
    .gain_in  (gain_dec),
    .s1_vld   (s1_vld),
    .s1_err   (s1_err),
    .s1_gain  (s1_gain)
  );

  pfc_pi_core #(
    .ERR_W   (ERR_W),
    .ACC_W   (ACC_W),
    .OUT_W   (OUT_W),
    .OUT_MAX (OUT_MAX)
  ) u_core (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .s1_vld  (s1_vld),
    .s1_err  (s1_err),
    .s1_gain (s1_gain),
    .pwr_dem (pwr_dem),
    .pwr_vld (pwr_vld)
  );

  // R1: enabled strobe yields a valid pulse two edges later
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    (en && valley) ##1 en |=> pwr_vld);

endmodule

// File: tb/pfc_pi_comp_tb.sv
`timescale 1ns/1ps
module pfc_pi_comp_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b1;
  logic        valley = 1'b0;
  logic [11:0] v_target = '0;
  logic [11:0] v_meas = '0;
  logic [2:0]  ki_sel = '0;
  logic [2:0]  kp_sel = '0;
  logic [15:0] pwr_dem;
  logic        pwr_vld;
  logic [19:0] s_dem;
  logic        s_vld;

  int n_chk = 0;
  int n_err = 0;
  longint m_acc = 0, s_acc = 0, m_out = 0, s_out = 0;

  int KI_T [8] = '{4, 6, 8, 12, 16, 24, 32, 48};
  int KP_T [8] = '{8, 12, 16, 24, 32, 48, 64, 96};

  always #2.5 clk = ~clk;

  pfc_pi_comp u_dut (
    .clk(clk), .rst(rst), .en(en), .valley(valley),
    .v_target(v_target), .v_meas(v_meas), .ki_sel(ki_sel), .kp_sel(kp_sel),
    .pwr_dem(pwr_dem), .pwr_vld(pwr_vld)
  );

  pfc_pi_comp #(.ACC_W(12), .OUT_W(20), .OUT_MAX(1000000)) u_sat (
    .clk(clk), .rst(rst), .en(en), .valley(valley),
    .v_target(v_target), .v_meas(v_meas), .ki_sel(ki_sel), .kp_sel(kp_sel),
    .pwr_dem(s_dem), .pwr_vld(s_vld)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input longint acc_in, input longint e, input longint ki,
                      input longint kp2, input longint amax, input longint omax,
                      output longint acc_out, output longint o);
    longint cand, r;
    cand = acc_in + e;
    if (cand > amax) cand = amax;
    if (cand < -amax - 1) cand = -amax - 1;
    r = kp2 * e + ki * cand;
    acc_out = cand;
    if (r > omax) begin
      o = omax;
      if (e > 0) acc_out = acc_in;
    end else if (r < 0) begin
      o = 0;
      if (e < 0) acc_out = acc_in;
    end else o = r;
  endtask

  task automatic model(input int tgt, input int meas, input int kc, input int pc);
    longint e, na;
    e = tgt - meas;
    if (e > 2047) e = 2047;
    if (e < -2048) e = -2048;
    step(m_acc, e, KI_T[kc], 2 * KP_T[pc], 64'd8388607, 50000, na, m_out);
    m_acc = na;
    step(s_acc, e, KI_T[kc], 2 * KP_T[pc], 64'd2047, 1000000, na, s_out);
    s_acc = na;
  endtask

  task automatic pulse(input int tgt, input int meas, input int kc, input int pc,
                       input string tag);
    @(negedge clk);
    v_target = 12'(tgt); v_meas = 12'(meas);
    ki_sel = 3'(kc); kp_sel = 3'(pc); valley = 1'b1;
    @(negedge clk);
    valley = 1'b0;
    chk("R1 early vld", pwr_vld, 0);
    model(tgt, meas, kc, pc);
    @(negedge clk);
    chk({tag, " vld"}, pwr_vld, 1);
    chk({tag, " dem"}, pwr_dem, m_out);
    chk({tag, " sat dem"}, s_dem, s_out);
    @(negedge clk);
    chk("R1 pulse width", pwr_vld, 0);
  endtask

  task automatic clear_loop();
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    m_acc = 0; s_acc = 0;
  endtask

  task automatic t_reset();
    chk("R12 reset dem", pwr_dem, 0);
    chk("R12 reset vld", pwr_vld, 0);
    pulse(2100, 2000, 0, 0, "R12 pre");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_acc = 0; s_acc = 0;
    chk("R12 mid reset dem", pwr_dem, 0);
    pulse(2000, 2000, 0, 0, "R12 cleared acc");
  endtask

  task automatic t_latency();
    clear_loop();
    pulse(2050, 2000, 1, 1, "R1");
    @(negedge clk);
    v_target = 12'd2030; v_meas = 12'd2000; valley = 1'b1;
    @(negedge clk);
    v_target = 12'd2010;
    model(2030, 2000, 1, 1);
    @(negedge clk);
    valley = 1'b0;
    chk("R1 b2b first vld", pwr_vld, 1);
    chk("R1 b2b first dem", pwr_dem, m_out);
    model(2010, 2000, 1, 1);
    @(negedge clk);
    chk("R1 b2b second vld", pwr_vld, 1);
    chk("R1 b2b second dem", pwr_dem, m_out);
    @(negedge clk);
    chk("R1 b2b end", pwr_vld, 0);
  endtask

  task automatic t_gains();
    for (int c = 0; c < 8; c++) begin
      clear_loop();
      pulse(2010, 2000, c, 0, "R3");
    end
    for (int c = 0; c < 8; c++) begin
      clear_loop();
      pulse(2010, 2000, 0, c, "R4");
    end
  endtask

  task automatic t_integ();
    clear_loop();
    for (int i = 0; i < 4; i++) pulse(2007, 2000, 2, 1, "R5");
    pulse(1997, 2000, 2, 1, "R5 down");
    pulse(2000, 2000, 2, 1, "R5 hold");
  endtask

  task automatic t_err_sat();
    clear_loop();
    pulse(4095, 0, 0, 0, "R2 pos sat");
    pulse(0, 4095, 0, 0, "R2 neg sat");
    pulse(2000, 2000, 0, 0, "R2 after");
  endtask

  task automatic t_hi_clamp();
    clear_loop();
    pulse(2500, 2000, 7, 7, "R6 clamp");
    pulse(2000, 2000, 7, 7, "R6 acc held");
    pulse(2100, 2000, 7, 0, "R6 recover");
  endtask

  task automatic t_lo_clamp();
    clear_loop();
    pulse(2100, 2000, 0, 0, "R7 build");
    pulse(1800, 2000, 0, 7, "R7 clamp");
    pulse(2000, 2000, 0, 0, "R7 acc held");
  endtask

  task automatic t_acc_sat();
    clear_loop();
    for (int i = 0; i < 3; i++) pulse(4095, 0, 0, 0, "R8 push");
    pulse(2000, 2000, 0, 0, "R8 saturated");
  endtask

  task automatic t_disable();
    clear_loop();
    pulse(2100, 2000, 0, 0, "R9 build");
    @(negedge clk); en = 1'b0; valley = 1'b1;
    @(negedge clk); valley = 1'b0;
    chk("R9 dem off", pwr_dem, 0);
    chk("R9 vld off", pwr_vld, 0);
    @(negedge clk);
    chk("R9 vld off later", pwr_vld, 0);
    en = 1'b1; m_acc = 0; s_acc = 0;
    pulse(2100, 2000, 0, 0, "R9 rebuild");
    @(negedge clk); v_target = 12'd2100; v_meas = 12'd2000; valley = 1'b1;
    @(negedge clk); valley = 1'b0; en = 1'b0;
    @(negedge clk);
    chk("R9 in flight vld", pwr_vld, 0);
    chk("R9 in flight dem", pwr_dem, 0);
    en = 1'b1; m_acc = 0; s_acc = 0;
    pulse(2000, 2000, 0, 0, "R9 acc cleared");
  endtask

  task automatic t_sample();
    clear_loop();
    @(negedge clk);
    v_target = 12'd2040; v_meas = 12'd2000; ki_sel = 3'd3; kp_sel = 3'd2; valley = 1'b1;
    @(negedge clk);
    valley = 1'b0;
    v_target = 12'd100; v_meas = 12'd3000; ki_sel = 3'd7; kp_sel = 3'd7;
    model(2040, 2000, 3, 2);
    @(negedge clk);
    chk("R10 vld", pwr_vld, 1);
    chk("R10 dem", pwr_dem, m_out);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      v_target = 12'(i * 700);
      chk("R11 hold dem", pwr_dem, m_out);
      chk("R11 hold vld", pwr_vld, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_latency();
    t_gains();
    t_integ();
    t_err_sat();
    t_hi_clamp();
    t_lo_clamp();
    t_acc_sat();
    t_disable();
    t_sample();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule